// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches one external interrupt pin and turns its activity into a request line for the interrupt sequencer. The pin first goes through a two-stage synchronizer. A 2-bit sense-mode input then picks what counts as an event: a low level, any change, a falling edge or a rising edge. In the three edge modes an event sets a pending flag. The flag stays set until the sequencer acknowledges the vector or software writes a one to clear it. In low-level mode no flag is kept, and the request simply follows the synchronized pin for as long as it stays low.

The block also holds an 8-bit mask register. Bit 6 enables this pin, bits 5 and 4 are stored pin-change enables for a neighbouring block, and the other bits read as zero. The request reaches the sequencer only when mask bit 6 and the global interrupt enable are both set. The block has no pin-direction input, so the pin raises events whether it is driven from outside or by the chip itself. This source is serviced at vector address 1 by the sequencer.

Top module: `pin_irq_sense`

## Requirements
- R1: Sense-mode encoding: 00 low level, 01 any change, 10 falling edge, 11 rising edge. In an edge mode, the selected transition of the synchronized pin sets the pending flag.
- R2: In low-level mode the flag is held at zero. The pending condition is the synchronized pin being low, and it ends as soon as the synchronized pin is high again.
- R3: A pin change reaches the synchronized sample two rising edges after it is applied. A resulting flag is visible after the third rising edge.
- R4: Once set, the flag stays set while no clear arrives and the mode stays an edge mode, even if the pin returns to its earlier level.
- R5: The flag is cleared by a sequencer acknowledge (vecAck) or by a software clear (swClr), one cycle after either one. If a new edge arrives in the same cycle, setting the flag wins.
- R6: irqReq is high only when mask bit 6 and globalEn are both set and the pending condition for the current mode holds.
- R7: The mask register resets to 0x00. A write stores bits 6 to 4, and bits 7 and 3 to 0 always read as zero.
- R8: Changing the sense mode while the pin is steady does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | External interrupt pin, asynchronous |
| senseMode | input | 2 | Trigger mode select (R1 encoding) |
| globalEn | input | 1 | Global interrupt enable |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 8 | Mask register write data |
| vecAck | input | 1 | Sequencer has vectored to this source |
| swClr | input | 1 | Software write of a one to the flag |
| maskRd | output | 8 | Mask register read value |
| flagOut | output | 1 | Pending flag |
| irqReq | output | 1 | Request to the interrupt sequencer |

## Verification
A pin change is due in the synchronized sample after two rising edges, and a flag caused by it is due after the third. A level-mode request is due after the second. A mask write, acknowledge or software clear shows after the next edge, while globalEn gates the request in the same cycle. The bench drives inputs on the falling edge and updates its reference model on the rising edge with the same register count. It compares every output at each falling edge, so each result is sampled in exactly the cycle it is due. The directed tests count edges explicitly, so they check the R3 latency against the cycle before it and the cycle it is due.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic holdZero;
  } flagCtl_t;
endpackage

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MASK_W      = 8,
  parameter int EN_BIT      = 6,
  parameter int PC_LO       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              maskWrEn,
  input  logic [MASK_W-1:0] maskWrData,
  input  flagCtl_t          ctl,
  output logic              syncPin,
  output logic              prevPin,
  output logic              flagQ,
  output logic [MASK_W-1:0] maskQ
);
  localparam int STORED_W = EN_BIT - PC_LO + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic [STORED_W-1:0]    maskBits;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b1;
        else if (i == 0) syncChain[i] <= pinIn;
        else syncChain[i] <= syncChain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncPin = syncChain[SYNC_STAGES-1];

  // previous sample follows every cycle so mode changes cannot fake an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= 1'b1;
    else prevPin <= syncPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else if (ctl.holdZero) flagQ <= 1'b0;
    else if (ctl.setFlag) flagQ <= 1'b1;
    else if (ctl.clrFlag) flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskBits <= '0;
    else if (maskWrEn) maskBits <= maskWrData[EN_BIT:PC_LO];
  end

  always_comb begin
    maskQ = '0;
    maskQ[EN_BIT:PC_LO] = maskBits;
  end

  // R4: a set flag survives without a clear
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !ctl.clrFlag && !ctl.holdZero |=> flagQ);
  // R5: a clear with no competing edge takes effect next cycle
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrFlag && !ctl.setFlag |=> !flagQ);
  // R7: reserved top bit reads zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[MASK_W-1] == 1'b0);
endmodule

// File: rtl/pin_irq_control.sv
module pin_irq_control
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] senseMode,
  input  logic       syncPin,
  input  logic       prevPin,
  input  logic       flagQ,
  input  logic       vecAck,
  input  logic       swClr,
  input  logic       maskEn,
  input  logic       globalEn,
  output flagCtl_t   ctl,
  output logic       irqReq
);
  senseMode_e mode;
  logic levelMode;
  logic edgeHit;
  logic pending;

  assign mode      = senseMode_e'(senseMode);
  assign levelMode = (mode == SENSE_LOW);

  always_comb begin
    case (mode)
      SENSE_ANY:  edgeHit = syncPin ^ prevPin;
      SENSE_FALL: edgeHit = prevPin & ~syncPin;
      SENSE_RISE: edgeHit = ~prevPin & syncPin;
      default:    edgeHit = 1'b0;
    endcase
  end

  always_comb begin
    ctl.holdZero = levelMode;
    ctl.setFlag  = edgeHit;
    ctl.clrFlag  = vecAck | swClr;
  end

  assign pending = levelMode ? ~syncPin : flagQ;
  assign irqReq  = pending & maskEn & globalEn;

  // R6: request only with both enables
  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalEn && maskEn));
  // R2: level mode keeps no flag
  a_r2_level_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    levelMode |=> !flagQ);
  // R1: falling transition in falling mode sets the flag
  a_r1_fall_sets: assert property (@(posedge clk) disable iff (!rstN)
    (mode == SENSE_FALL) && prevPin && !syncPin |=> flagQ);
  // R8: steady pin never raises a cleared flag, whatever the mode
  a_r8_steady_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (syncPin == prevPin) && !flagQ |=> !flagQ);
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MASK_W      = 8,
  parameter int EN_BIT      = 6,
  parameter int PC_LO       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [1:0]        senseMode,
  input  logic              globalEn,
  input  logic              maskWrEn,
  input  logic [MASK_W-1:0] maskWrData,
  input  logic              vecAck,
  input  logic              swClr,
  output logic [MASK_W-1:0] maskRd,
  output logic              flagOut,
  output logic              irqReq
);
  flagCtl_t ctl;
  logic syncPin;
  logic prevPin;

  pin_irq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .MASK_W(MASK_W), .EN_BIT(EN_BIT), .PC_LO(PC_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .ctl(ctl), .syncPin(syncPin), .prevPin(prevPin),
    .flagQ(flagOut), .maskQ(maskRd)
  );

  pin_irq_control u_ctl (
    .clk(clk), .rstN(rstN), .senseMode(senseMode), .syncPin(syncPin),
    .prevPin(prevPin), .flagQ(flagOut), .vecAck(vecAck), .swClr(swClr),
    .maskEn(maskRd[EN_BIT]), .globalEn(globalEn), .ctl(ctl), .irqReq(irqReq)
  );
endmodule

// File: tb/sim_pin_irq_sense.sv
module sim_pin_irq_sense;
  logic clk = 0;
  logic rstN = 0;
  logic pinIn = 1;
  logic [1:0] senseMode = 2'b10;
  logic globalEn = 0;
  logic maskWrEn = 0;
  logic [7:0] maskWrData = 0;
  logic vecAck = 0;
  logic swClr = 0;
  logic [7:0] maskRd;
  logic flagOut;
  logic irqReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  logic m1 = 1, m2 = 1, mp = 1, mFlag = 0;
  logic [7:0] mMask = 0;

  always #4 clk = ~clk;  // 125 MHz

  pin_irq_sense u0 (.*);

  function automatic logic edgeFn(input logic [1:0] md, input logic cur, input logic prv);
    case (md)
      2'b01: return cur ^ prv;
      2'b10: return prv & ~cur;
      2'b11: return ~prv & cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic reqFn(input logic [1:0] md, input logic s, input logic f,
                                 input logic [7:0] mk, input logic ge);
    return ge & mk[6] & ((md == 2'b00) ? ~s : f);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 1; m2 <= 1; mp <= 1; mFlag <= 0; mMask <= 0;
    end else begin
      m1 <= pinIn; m2 <= m1; mp <= m2;
      if (senseMode == 2'b00) mFlag <= 0;
      else if (edgeFn(senseMode, m2, mp)) mFlag <= 1;
      else if (vecAck | swClr) mFlag <= 0;
      if (maskWrEn) mMask <= {1'b0, maskWrData[6:4], 4'b0};
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model comparison away from the active edge (all requirements, R1-style tags below)
  bit autoCheck = 0;
  always @(negedge clk) if (autoCheck && rstN) begin
    check("R1/R4/R5 flag", {7'b0, flagOut}, {7'b0, mFlag});
    check("R6/R2 irqReq", {7'b0, irqReq}, {7'b0, reqFn(senseMode, m2, mFlag, mMask, globalEn)});
    check("R7 mask", maskRd, mMask);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1600000;
    nFail++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R7 reset mask", maskRd, 8'h00);
    check("R4 reset flag", {7'b0, flagOut}, 8'h0);
    rstN = 1;
    cyc(1);
    // R7: write all ones, only bits 6..4 stick
    maskWrEn = 1; maskWrData = 8'hFF; cyc(1); maskWrEn = 0;
    check("R7 reserved bits", maskRd, 8'h70);
    globalEn = 1;
    // R3: falling edge latency, flag after third edge
    pinIn = 0; cyc(2);
    check("R3 not yet", {7'b0, flagOut}, 8'h0);
    cyc(1);
    check("R3 flag due", {7'b0, flagOut}, 8'h1);
    check("R6 req up", {7'b0, irqReq}, 8'h1);
    // R4: pin returns high, flag persists
    pinIn = 1; cyc(4);
    check("R4 persists", {7'b0, flagOut}, 8'h1);
    // R6: global enable gates same cycle
    globalEn = 0; #1;
    check("R6 global gate", {7'b0, irqReq}, 8'h0);
    globalEn = 1;
    // R5: software clear
    swClr = 1; cyc(1); swClr = 0;
    check("R5 sw clear", {7'b0, flagOut}, 8'h0);
    // R8: mode changes with steady pin
    senseMode = 2'b01; cyc(2); senseMode = 2'b11; cyc(2); senseMode = 2'b10; cyc(2);
    check("R8 no spurious", {7'b0, flagOut}, 8'h0);
    // R2: level mode follows pin, no flag
    senseMode = 2'b00; pinIn = 0; cyc(1);
    check("R2 level not yet", {7'b0, irqReq}, 8'h0);
    cyc(1);
    check("R2 level req", {7'b0, irqReq}, 8'h1);
    check("R2 level no flag", {7'b0, flagOut}, 8'h0);
    pinIn = 1; cyc(2);
    check("R2 level drops", {7'b0, irqReq}, 8'h0);
    // R1 rising mode + R5 ack with simultaneous edge: set wins
    senseMode = 2'b11; pinIn = 0; cyc(3); pinIn = 1; cyc(2);
    vecAck = 1; cyc(1); vecAck = 0;
    check("R5 set wins", {7'b0, flagOut}, 8'h1);
    vecAck = 1; cyc(1); vecAck = 0;
    check("R5 ack clear", {7'b0, flagOut}, 8'h0);
    // R6: mask bit 6 off
    maskWrEn = 1; maskWrData = 8'h30; cyc(1); maskWrEn = 0;
    senseMode = 2'b00; pinIn = 0; cyc(3);
    check("R6 mask gate", {7'b0, irqReq}, 8'h0);
    // constrained random against the model
    autoCheck = 1;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      pinIn = ($urandom % 4) != 0 ? pinIn : ~pinIn;
      if ($urandom % 16 == 0) senseMode = 2'($urandom);
      globalEn = ($urandom % 8) != 0;
      maskWrEn = ($urandom % 32) == 0;
      maskWrData = 8'($urandom);
      vecAck = ($urandom % 12) == 0;
      swClr = ($urandom % 16) == 0;
      cyc(1);
    end
    autoCheck = 0;
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule